// File: doc/BRIEF.md
# Predictive Output Port Selector

This block chooses the output port for a packet's head flit inside a five-port mesh router. Four ports face the mesh neighbours and one faces the local node. For each port it keeps a small up/down counter of recent blocking. The counter rises each time traffic toward that port is held up and falls each time traffic gets through. An upstream routing function offers one or two candidate ports. The selector tries the candidate with the lower blocking history first. If that port cannot take the packet, it tries the other candidate. The port it settles on is granted in the same cycle.

The counters also learn from the data phase. For each output the crossbar has configured, the router reports whether the flit moved or was held by a downstream stall. A stall raises that port's counter and a successful move lowers it. Over time, traffic is steered away from congested regions, much as a branch predictor steers fetch.

The request side is a valid/ready pair. The requester raises `req_valid` with its candidates and keeps them unchanged until `req_ready` is seen high on a clock edge. `req_ready` is the grant. It is combinational from the inputs and the current counters, and `grant_port` is meaningful only while it is high. A request that is refused still updates the counters, so a held request may be granted on a later cycle.

Top module: `pred_port_sel`

## Requirements
- R1: A synchronous active-high reset clears every port counter to zero. The first tie after reset therefore favours the second candidate.
- R2: When two distinct candidates are offered, the one whose counter is strictly lower is tried first. On equal counters, or when the first candidate's counter is higher, the second candidate (`req_dir_b`) is tried first.
- R3: With a single candidate (`req_pair` = 0), only `req_dir_a` is considered. It is granted exactly when its `port_free` bit is 1; there is no alternative.
- R4: If the first-tried port is free, it is granted in the same cycle (`req_ready` = 1, `grant_port` = its index) and its counter is decremented.
- R5: If the first-tried port is not free, its counter is incremented and the other candidate, if present, is tried. A free alternative is granted and its counter decremented. A busy alternative has its counter incremented and `req_ready` stays 0.
- R6: For each port i with `fwd_active[i]` = 1, `fwd_stall[i]` = 1 increments counter i and `fwd_stall[i]` = 0 decrements it. A port with `fwd_active[i]` = 0 is unaffected by `fwd_stall[i]`.
- R7: Counters are 4-bit and saturate at 0 and 15; they never wrap.
- R8: When a route update and a forward update reach the same counter in one cycle, their net effect is applied: +1 and -1 cancel, and two like changes add before saturation.
- R9: `req_ready` is 0 whenever `req_valid` is 0, and no counter changes from routing then. `grant_port` is 0 whenever `req_ready` is 0.
- R10: A pair whose two indices are equal is handled as a single candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Head flit requests a route |
| req_ready | output | 1 | Route granted this cycle; the request is consumed |
| req_pair | input | 1 | 1 when `req_dir_b` is also an allowed candidate |
| req_dir_a | input | 3 | First candidate port index (0..4) |
| req_dir_b | input | 3 | Second candidate port index (0..4) |
| port_free | input | 5 | Per-port: output is available and unblocked |
| grant_port | output | 3 | Granted port index; 0 when no grant |
| fwd_active | input | 5 | Per-port: a configured output attempted a forward |
| fwd_stall | input | 5 | Per-port: that forward was held by a downstream block |

## Verification
A wrong counter value does not appear on any pin at once. It shows the first time that counter is compared against another in a two-candidate request. There it flips which port is tried first, and so which index is granted or whether anything is granted at all. The bench therefore keeps its own arithmetic model of all five counters and compares `req_ready` and `grant_port` on every cycle. It sweeps every candidate pairing against every free pattern while forward outcomes vary, so a corrupted counter is exposed within a few requests of going wrong. Directed runs drive counters into both saturation limits and into same-cycle opposing updates, then probe their order through preferences.

// File: rtl/pred_port_sel_pkg.sv
package pred_port_sel_pkg;

  // One counter adjustment request from a single source.
  typedef struct packed {
    logic up;
    logic dn;
  } hist_step_t;

  // Net change from a routing step and a forward step, range -2..+2.
  function automatic logic signed [2:0] net_change(hist_step_t r, hist_step_t f);
    logic signed [2:0] acc;
    acc = 3'sd0;
    if (r.up) acc = acc + 3'sd1;
    if (r.dn) acc = acc - 3'sd1;
    if (f.up) acc = acc + 3'sd1;
    if (f.dn) acc = acc - 3'sd1;
    return acc;
  endfunction

endpackage

// File: rtl/pred_port_sel_choose.sv
module pred_port_sel_choose
  import pred_port_sel_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int CNT_W     = 4,
  parameter int PORT_W    = 3
) (
  input  logic                              req_valid,
  input  logic                              req_pair,
  input  logic [PORT_W-1:0]                 req_dir_a,
  input  logic [PORT_W-1:0]                 req_dir_b,
  input  logic [NUM_PORTS-1:0]              port_free,
  input  logic [NUM_PORTS-1:0][CNT_W-1:0]   hist,
  output hist_step_t [NUM_PORTS-1:0]        route_step,
  output logic                              granted,
  output logic [PORT_W-1:0]                 grant_idx
);

  logic              two_way;
  logic [PORT_W-1:0] first_idx;
  logic [PORT_W-1:0] second_idx;
  logic              first_ok;
  logic              second_ok;

  // Candidate ordering from the blocking history.
  always_comb begin
    two_way    = req_pair && (req_dir_a != req_dir_b);
    first_idx  = req_dir_a;
    second_idx = req_dir_b;
    if (two_way && !(hist[req_dir_a] < hist[req_dir_b])) begin
      first_idx  = req_dir_b;
      second_idx = req_dir_a;
    end
    first_ok  = port_free[first_idx];
    second_ok = two_way && port_free[second_idx];
  end

  // Attempt sequence and the counter steps it produces.
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      route_step[p] = '0;
    end
    granted   = 1'b0;
    grant_idx = '0;
    if (req_valid) begin
      if (first_ok) begin
        route_step[first_idx].dn = 1'b1;
        granted   = 1'b1;
        grant_idx = first_idx;
      end else begin
        route_step[first_idx].up = 1'b1;
        if (two_way) begin
          if (second_ok) begin
            route_step[second_idx].dn = 1'b1;
            granted   = 1'b1;
            grant_idx = second_idx;
          end else begin
            route_step[second_idx].up = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pred_port_sel_history.sv
module pred_port_sel_history
  import pred_port_sel_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int CNT_W     = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  hist_step_t [NUM_PORTS-1:0]       route_step,
  input  logic [NUM_PORTS-1:0]             fwd_active,
  input  logic [NUM_PORTS-1:0]             fwd_stall,
  output logic [NUM_PORTS-1:0][CNT_W-1:0]  hist
);

  localparam int SUM_W = CNT_W + 2;
  localparam logic signed [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hist_step_t              fwd_step;
    logic signed [2:0]       delta;
    logic signed [SUM_W-1:0] sum;
    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        cnt_d;

    always_comb begin
      fwd_step.up = fwd_active[p] && fwd_stall[p];
      fwd_step.dn = fwd_active[p] && !fwd_stall[p];
      delta = net_change(route_step[p], fwd_step);
      sum   = $signed({2'b00, cnt_q}) + {{(SUM_W-3){delta[2]}}, delta};
      if (sum < 0)            cnt_d = '0;
      else if (sum > CNT_MAX) cnt_d = CNT_MAX[CNT_W-1:0];
      else                    cnt_d = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
    end

    assign hist[p] = cnt_q;
  end

endmodule

// File: rtl/pred_port_sel.sv
module pred_port_sel
  import pred_port_sel_pkg::*;
#(
  parameter int  NUM_PORTS = 5,
  parameter int  CNT_W     = 4,
  localparam int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_pair,
  input  logic [PORT_W-1:0]     req_dir_a,
  input  logic [PORT_W-1:0]     req_dir_b,
  input  logic [NUM_PORTS-1:0]  port_free,
  output logic [PORT_W-1:0]     grant_port,
  input  logic [NUM_PORTS-1:0]  fwd_active,
  input  logic [NUM_PORTS-1:0]  fwd_stall
);

  hist_step_t [NUM_PORTS-1:0]      route_step;
  logic [NUM_PORTS-1:0][CNT_W-1:0] hist;

  pred_port_sel_choose #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W),
    .PORT_W    (PORT_W)
  ) u_choose (
    .req_valid  (req_valid),
    .req_pair   (req_pair),
    .req_dir_a  (req_dir_a),
    .req_dir_b  (req_dir_b),
    .port_free  (port_free),
    .hist       (hist),
    .route_step (route_step),
    .granted    (req_ready),
    .grant_idx  (grant_port)
  );

  pred_port_sel_history #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W)
  ) u_history (
    .clk        (clk),
    .rst        (rst),
    .route_step (route_step),
    .fwd_active (fwd_active),
    .fwd_stall  (fwd_stall),
    .hist       (hist)
  );

endmodule

// File: rtl/pred_port_sel_chk.sv
module pred_port_sel_chk #(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_pair,
  input logic [PORT_W-1:0]    req_dir_a,
  input logic [PORT_W-1:0]    req_dir_b,
  input logic [NUM_PORTS-1:0] port_free,
  input logic [PORT_W-1:0]    grant_port
);

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> req_valid); // R9

  AST_IDLE_PORT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> grant_port == '0); // R9

  AST_GRANT_IS_FREE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> port_free[grant_port]); // R4

  AST_GRANT_IS_CANDIDATE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (grant_port == req_dir_a) || (req_pair && grant_port == req_dir_b)); // R5

  AST_SINGLE_NO_ALT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_pair) |-> (req_ready == port_free[req_dir_a])); // R3

  AST_PAIR_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pair && (req_dir_a != req_dir_b)
     && (port_free[req_dir_a] || port_free[req_dir_b])) |-> req_ready); // R5

  AST_SAME_PAIR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pair && (req_dir_a == req_dir_b))
    |-> (req_ready == port_free[req_dir_a])); // R10

endmodule

bind pred_port_sel pred_port_sel_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_pair   (req_pair),
  .req_dir_a  (req_dir_a),
  .req_dir_b  (req_dir_b),
  .port_free  (port_free),
  .grant_port (grant_port)
);

// File: tb/pred_port_sel_tb.sv
module pred_port_sel_tb;

  localparam int NP = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic       req_ready;
  logic       req_pair;
  logic [2:0] req_dir_a;
  logic [2:0] req_dir_b;
  logic [4:0] port_free;
  logic [2:0] grant_port;
  logic [4:0] fwd_active;
  logic [4:0] fwd_stall;

  int n_cmp  = 0;
  int n_bad  = 0;
  int model [NP];
  bit done   = 0;

  always #10 clk = ~clk;

  pred_port_sel u_dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pair   (req_pair),
    .req_dir_a  (req_dir_a),
    .req_dir_b  (req_dir_b),
    .port_free  (port_free),
    .grant_port (grant_port),
    .fwd_active (fwd_active),
    .fwd_stall  (fwd_stall)
  );

  function automatic int clamp(int v);
    if (v < 0)  return 0;
    if (v > 15) return 15;
    return v;
  endfunction

  // Inputs are driven just after a falling edge; compare outputs, then
  // advance the model to the value the rising edge will load.
  task automatic step(input string tag);
    int  d [NP];
    bit  two;
    int  first, second;
    bit  exp_rdy;
    int  exp_port;
    #1;
    for (int p = 0; p < NP; p++) d[p] = 0;
    two      = req_pair && (req_dir_a != req_dir_b);
    first    = req_dir_a;
    second   = req_dir_b;
    if (two && !(model[req_dir_a] < model[req_dir_b])) begin
      first  = req_dir_b;
      second = req_dir_a;
    end
    exp_rdy  = 0;
    exp_port = 0;
    if (req_valid) begin
      if (port_free[first]) begin
        exp_rdy = 1; exp_port = first; d[first] -= 1;
      end else begin
        d[first] += 1;
        if (two) begin
          if (port_free[second]) begin
            exp_rdy = 1; exp_port = second; d[second] -= 1;
          end else d[second] += 1;
        end
      end
    end
    for (int p = 0; p < NP; p++)
      if (fwd_active[p]) d[p] += fwd_stall[p] ? 1 : -1;
    n_cmp++;
    if (req_ready !== exp_rdy || int'(grant_port) !== exp_port) begin
      n_bad++;
      $display("FAIL %s: ready/port got %0b/%0d expected %0b/%0d (a=%0d b=%0d pair=%0b free=%b)",
               tag, req_ready, grant_port, exp_rdy, exp_port,
               req_dir_a, req_dir_b, req_pair, port_free);
    end
    for (int p = 0; p < NP; p++) model[p] = clamp(model[p] + d[p]);
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input bit pr, input int a, input int b,
                       input logic [4:0] fr, input logic [4:0] fa,
                       input logic [4:0] fs);
    req_valid  = v;
    req_pair   = pr;
    req_dir_a  = 3'(a);
    req_dir_b  = 3'(b);
    port_free  = fr;
    fwd_active = fa;
    fwd_stall  = fs;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 0, 5'h00, 5'h00, 5'h00);
    for (int p = 0; p < NP; p++) model[p] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: idle request, no grant and port index zero.
    drive(0, 1, 3, 4, 5'h1F, 5'h00, 5'h00);
    step("R9 idle");

    // R1: all counters zero, tie favours second candidate.
    drive(1, 1, 0, 1, 5'h1F, 5'h00, 5'h00);
    step("R1 reset tie");

    // R6 R7: stall port 2 for 20 cycles, saturates at 15.
    for (int i = 0; i < 20; i++) begin
      drive(0, 0, 0, 0, 5'h00, 5'b00100, 5'b00100);
      step("R6 stall");
    end
    // R2 R7: counter 2 = 15 vs port 3 = 0, both orders.
    drive(1, 1, 2, 3, 5'h1F, 5'h00, 5'h00);
    step("R7 high sat order");
    drive(1, 1, 3, 2, 5'h1F, 5'h00, 5'h00);
    step("R2 lower preferred");

    // R8: port 2 busy single route (+1) and successful forward (-1).
    for (int i = 0; i < 4; i++) begin
      drive(1, 0, 2, 0, 5'b11011, 5'b00100, 5'b00000);
      step("R8 net cancel");
    end
    // R6: drain port 2 to zero and beyond (R7 low saturation).
    for (int i = 0; i < 18; i++) begin
      drive(0, 0, 0, 0, 5'h00, 5'b00100, 5'b00000);
      step("R7 low sat");
    end
    drive(1, 1, 2, 4, 5'h1F, 5'h00, 5'h00);
    step("R2 tie after drain");

    // R6: stall flag without active must not move counter 1.
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 0, 0, 5'h00, 5'b00000, 5'b00010);
      step("R6 inactive stall");
    end
    drive(1, 1, 1, 0, 5'h1F, 5'h00, 5'h00);
    step("R6 inactive probe");

    // R3 R5 R10 single, fallback and identical pair.
    drive(1, 0, 4, 1, 5'b01111, 5'h00, 5'h00);
    step("R3 single busy");
    drive(1, 1, 3, 3, 5'b10111, 5'h00, 5'h00);
    step("R10 same pair");
    drive(1, 1, 0, 1, 5'b00000, 5'h00, 5'h00);
    step("R5 both busy");
    drive(1, 1, 0, 1, 5'b00001, 5'h00, 5'h00);
    step("R5 fallback");
    drive(1, 1, 0, 1, 5'b00011, 5'h00, 5'h00);
    step("R4 first free");

    // Sweep: every pairing against every free pattern, forwards varied.
    for (int rep = 0; rep < 2; rep++)
      for (int a = 0; a < NP; a++)
        for (int b = 0; b < NP; b++)
          for (int pr = 0; pr < 2; pr++)
            for (int fr = 0; fr < 32; fr++) begin
              drive(1, pr[0], a, b, 5'(fr), 5'($urandom), 5'($urandom));
              step(pr[0] ? "R2 R5 sweep" : "R3 R4 sweep");
            end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule